// File: doc/BRIEF.md
# Interrupt and Hold-Wakeup Controller

This block collects the event sources of a small microcontroller: a prescaler overflow pulse, underflow pulses from two timers, a four-pin input port that reports any pin toggle, and an active-low external interrupt pin that reports falling edges. Each source latches into its own bit of an eight-bit event flag vector. Two write-only enable registers then use that vector. One selects which flags may raise an interrupt request to the CPU. The other selects which flags may end hold (sleep) mode. A third write-only register picks which port pins can produce the port-toggle event.

The CPU side sees a request line, a 3-bit vector index and a one-cycle acknowledge input. Accepting an interrupt clears only the accepted flag and masks every interrupt. The mask stays on until software rewrites the interrupt enable register or issues the global enable command. A global disable command masks all requests and leaves the enable register as it was. Hold release is a one-clock pulse. It does not depend on the global interrupt mask.

Top module: `irq_wake_ctrl`

## Requirements
- R1: Flag bits map as follows: prescaler overflow is bit 0, timer-0 underflow is bit 1, port toggle is bit 2, external falling edge is bit 4 and timer-1 underflow is bit 7. Bits 3, 5 and 6 are never set, and setting them in an enable register has no effect. While a request is raised, the vector index equals the number of the flag bit being requested.
- R2: A pulse on the prescaler or timer inputs sets its flag at the next clock edge. The flag is set whether or not that source is enabled.
- R3: When an interrupt is acknowledged, only the acknowledged flag bit is cleared. Every other flag bit keeps its value.
- R4: After an acknowledge, no request is raised until the interrupt enable register is written or the global enable command is given. If one of these happens in the same cycle as the acknowledge, it wins and the mask stays open.
- R5: The global disable command drops the request at the next edge and overrides a same-cycle enable. It does not alter the interrupt enable register: a later global enable command restores the same request and vector.
- R6: A toggle on a port pin sets flag bit 2 only when that pin's bit in the port enable register is 1. Bit n of that register gates pin n.
- R7: The external source sets flag bit 4 on a high-to-low transition of the pin. Holding the pin low does not set it again.
- R8: When several enabled flags are pending, the lowest-numbered one is requested first.
- R9: After reset, all flags and enable registers are zero, the global mask is closed, and irq_req_o and hold_release_o are low.
- R10: hold_release_o pulses high for one clock in the same cycle a flag is set whose bit is 1 in the hold-release enable register. The global mask does not affect this. A source whose hold-release bit is 0 never produces the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_ovf_i | input | 1 | Prescaler overflow pulse |
| tmr0_unf_i | input | 1 | Timer-0 underflow pulse |
| tmr1_unf_i | input | 1 | Timer-1 underflow pulse |
| port_i | input | 4 | Asynchronous port pins |
| ext_n_i | input | 1 | Asynchronous external interrupt pin, active low |
| ien_we_i | input | 1 | Write strobe for the interrupt enable register |
| ien_wdata_i | input | 8 | Interrupt enable write data |
| hren_we_i | input | 1 | Write strobe for the hold-release enable register |
| hren_wdata_i | input | 8 | Hold-release enable write data |
| pen_we_i | input | 1 | Write strobe for the port enable register |
| pen_wdata_i | input | 4 | Port enable write data |
| gie_set_i | input | 1 | Global interrupt enable command |
| gie_clr_i | input | 1 | Global interrupt disable command |
| irq_ack_i | input | 1 | Interrupt acknowledge, one cycle |
| irq_req_o | output | 1 | Interrupt request |
| irq_vec_o | output | 3 | Index of the requested flag |
| hold_release_o | output | 1 | One-clock hold-release pulse |
| evt_o | output | 8 | Event flag vector |

## Verification
The synchronous pulses reach evt_o and hold_release_o at the first edge after the pulse. After that edge, irq_req_o and irq_vec_o follow combinationally from the latched state. Pin toggles and the external edge take three edges: two synchronizer stages and then the flag register. The bench drives every input on a falling clock edge and samples on a later falling edge. For pin stimuli it waits three falling edges. Acknowledge, enable and disable effects are sampled one falling edge after the edge that registers them.

// File: rtl/irqw_pkg.sv
package irqw_pkg;
  localparam int NUM_SRC  = 8;
  localparam int VEC_W    = $clog2(NUM_SRC);
  localparam int PORT_W   = 4;

  localparam int SRC_DIV  = 0;
  localparam int SRC_T0   = 1;
  localparam int SRC_PORT = 2;
  localparam int SRC_EXT  = 4;
  localparam int SRC_T1   = 7;

  localparam logic [NUM_SRC-1:0] IMPL_MASK =
    NUM_SRC'((1 << SRC_DIV) | (1 << SRC_T0) | (1 << SRC_PORT) |
             (1 << SRC_EXT) | (1 << SRC_T1));

  function automatic logic [VEC_W-1:0] lowest_set(input logic [NUM_SRC-1:0] v);
    logic [VEC_W-1:0] idx;
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (v[i]) idx = VEC_W'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/irqw_pin_sync.sv
module irqw_pin_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din_i,
  input  logic [W-1:0] rst_val_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = din_i;
      end else begin : g_next
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= rst_val_i;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= rst_val_i;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign cur_o  = stage_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/irqw_evt_flags.sv
module irqw_evt_flags
  import irqw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] flags_o
);
  logic [NUM_SRC-1:0] flags_q, flags_d;
  logic               flags_en;

  always_comb begin
    // a new event in the same cycle wins over the clear
    flags_d  = ((flags_q & ~clr_i) | set_i) & IMPL_MASK;
    flags_en = |set_i | |clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/irqw_arbiter.sv
module irqw_arbiter
  import irqw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] flags_i,
  input  logic [NUM_SRC-1:0] ien_i,
  input  logic               open_i,
  input  logic               close_i,
  input  logic               ack_i,
  output logic               req_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [NUM_SRC-1:0] clr_o
);
  logic               gie_q, gie_d, gie_en;
  logic [NUM_SRC-1:0] pending;
  logic               accept;

  always_comb begin
    pending = flags_i & ien_i & IMPL_MASK;
    req_o   = gie_q & |pending;
    vec_o   = lowest_set(pending);
    accept  = req_o & ack_i;
    clr_o   = accept ? (NUM_SRC'(1) << vec_o) : '0;
  end

  always_comb begin
    gie_d  = gie_q;
    gie_en = close_i | open_i | accept;
    if (close_i)     gie_d = 1'b0;
    else if (open_i) gie_d = 1'b1;
    else if (accept) gie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gie_q <= 1'b0;
    else if (gie_en) gie_q <= gie_d;
  end
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
  import irqw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_ovf_i,
  input  logic              tmr0_unf_i,
  input  logic              tmr1_unf_i,
  input  logic [3:0]        port_i,
  input  logic              ext_n_i,
  input  logic              ien_we_i,
  input  logic [7:0]        ien_wdata_i,
  input  logic              hren_we_i,
  input  logic [7:0]        hren_wdata_i,
  input  logic              pen_we_i,
  input  logic [3:0]        pen_wdata_i,
  input  logic              gie_set_i,
  input  logic              gie_clr_i,
  input  logic              irq_ack_i,
  output logic              irq_req_o,
  output logic [2:0]        irq_vec_o,
  output logic              hold_release_o,
  output logic [7:0]        evt_o
);
  localparam int PIN_W = PORT_W + 1;

  logic [NUM_SRC-1:0] ien_q, hren_q;
  logic [PORT_W-1:0]  pen_q;
  logic               hold_q, hold_d;

  logic [PIN_W-1:0]   pin_cur, pin_prev, pin_rst;
  logic [PORT_W-1:0]  port_toggle;
  logic               ext_fall;
  logic [NUM_SRC-1:0] set_vec, clr_vec, flags;

  // enable registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ien_q <= '0;
    else if (ien_we_i) ien_q <= ien_wdata_i & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hren_q <= '0;
    else if (hren_we_i) hren_q <= hren_wdata_i & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pen_q <= '0;
    else if (pen_we_i) pen_q <= pen_wdata_i;
  end

  // pin synchronizer: port pins low, external pin high (idle) at reset
  assign pin_rst = {1'b1, {PORT_W{1'b0}}};

  irqw_pin_sync #(.W(PIN_W), .STAGES(2)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .din_i     ({ext_n_i, port_i}),
    .rst_val_i (pin_rst),
    .cur_o     (pin_cur),
    .prev_o    (pin_prev)
  );

  always_comb begin
    port_toggle = (pin_cur[PORT_W-1:0] ^ pin_prev[PORT_W-1:0]) & pen_q;
    ext_fall    = pin_prev[PORT_W] & ~pin_cur[PORT_W];
    set_vec           = '0;
    set_vec[SRC_DIV]  = div_ovf_i;
    set_vec[SRC_T0]   = tmr0_unf_i;
    set_vec[SRC_PORT] = |port_toggle;
    set_vec[SRC_EXT]  = ext_fall;
    set_vec[SRC_T1]   = tmr1_unf_i;
    hold_d            = |(set_vec & hren_q);
  end

  irqw_evt_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .flags_o (flags)
  );

  irqw_arbiter u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags_i (flags),
    .ien_i   (ien_q),
    .open_i  (ien_we_i | gie_set_i),
    .close_i (gie_clr_i),
    .ack_i   (irq_ack_i),
    .req_o   (irq_req_o),
    .vec_o   (irq_vec_o),
    .clr_o   (clr_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign hold_release_o = hold_q;
  assign evt_o          = flags;
endmodule

// File: rtl/irq_wake_ctrl_chk.sv
module irq_wake_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_req_o,
  input logic [2:0] irq_vec_o,
  input logic       irq_ack_i,
  input logic [7:0] evt_o,
  input logic       ien_we_i,
  input logic       gie_set_i,
  input logic       gie_clr_i
);
  AST_REQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> evt_o[irq_vec_o]); // R1

  AST_VEC_IMPLEMENTED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (irq_vec_o inside {3'd0, 3'd1, 3'd2, 3'd4, 3'd7})); // R1

  AST_RSVD_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o & 8'h68) == 8'h00); // R1

  AST_ACK_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && irq_ack_i) |=>
      ((evt_o & $past(evt_o & ~(8'd1 << irq_vec_o))) ==
       $past(evt_o & ~(8'd1 << irq_vec_o)))); // R3

  AST_ACK_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && irq_ack_i && !ien_we_i && !gie_set_i) |=> !irq_req_o); // R4

  AST_DISABLE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr_i |=> !irq_req_o); // R5
endmodule

bind irq_wake_ctrl irq_wake_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_req_o (irq_req_o),
  .irq_vec_o (irq_vec_o),
  .irq_ack_i (irq_ack_i),
  .evt_o     (evt_o),
  .ien_we_i  (ien_we_i),
  .gie_set_i (gie_set_i),
  .gie_clr_i (gie_clr_i)
);

// File: tb/irq_wake_ctrl_tb.sv
module irq_wake_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       div_ovf_i = 0, tmr0_unf_i = 0, tmr1_unf_i = 0;
  logic [3:0] port_i = '0;
  logic       ext_n_i = 1'b1;
  logic       ien_we_i = 0, hren_we_i = 0, pen_we_i = 0;
  logic [7:0] ien_wdata_i = '0, hren_wdata_i = '0;
  logic [3:0] pen_wdata_i = '0;
  logic       gie_set_i = 0, gie_clr_i = 0, irq_ack_i = 0;
  logic       irq_req_o, hold_release_o;
  logic [2:0] irq_vec_o;
  logic [7:0] evt_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  irq_wake_ctrl u_dut (.*);

  // {div,t0,t1}, ien, exp_req, exp_vec
  localparam logic [14:0] VECS [8] = '{
    {3'b100, 8'h01, 1'b1, 3'd0},
    {3'b010, 8'h02, 1'b1, 3'd1},
    {3'b001, 8'h80, 1'b1, 3'd7},
    {3'b101, 8'h81, 1'b1, 3'd0},
    {3'b011, 8'h80, 1'b1, 3'd7},
    {3'b100, 8'h68, 1'b0, 3'd0},
    {3'b111, 8'hFE, 1'b1, 3'd1},
    {3'b001, 8'h7F, 1'b0, 3'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ien(input logic [7:0] v);
    ien_we_i = 1; ien_wdata_i = v; tick(); ien_we_i = 0;
  endtask

  task automatic drain();
    ien_we_i = 1; ien_wdata_i = 8'hFF; irq_ack_i = 1;
    tick(8);
    irq_ack_i = 0; ien_wdata_i = 8'h00; tick();
    ien_we_i = 0; gie_clr_i = 1; tick(); gie_clr_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R9 reset state
    chk("R9 evt", evt_o, 8'h00);
    chk("R9 req", irq_req_o, 1'b0);
    chk("R9 hold", hold_release_o, 1'b0);
    rst_n = 1'b1;
    tick(2);
    chk("R9 req after release", irq_req_o, 1'b0);

    // table walk: R1 R2 R8
    for (int i = 0; i < 8; i++) begin
      logic [14:0] v;
      v = VECS[i];
      write_ien(v[11:4]);
      div_ovf_i = v[14]; tmr0_unf_i = v[13]; tmr1_unf_i = v[12];
      tick();
      div_ovf_i = 0; tmr0_unf_i = 0; tmr1_unf_i = 0;
      chk("R2 flags set", evt_o, {v[12], 5'b0, v[13], v[14]});
      chk("R1/R8 req", irq_req_o, v[3]);
      if (v[3]) chk("R1/R8 vec", irq_vec_o, v[2:0]);
      drain();
    end

    // R3 R4: accept clears only its bit and masks
    write_ien(8'h03);
    div_ovf_i = 1; tmr0_unf_i = 1; tick(); div_ovf_i = 0; tmr0_unf_i = 0;
    chk("R8 lowest first", irq_vec_o, 3'd0);
    irq_ack_i = 1; tick(); irq_ack_i = 0;
    chk("R3 only acked bit cleared", evt_o, 8'h02);
    chk("R4 masked after accept", irq_req_o, 1'b0);
    tick(2);
    chk("R4 still masked", irq_req_o, 1'b0);
    gie_set_i = 1; tick(); gie_set_i = 0;
    chk("R4 enable command reopens", irq_req_o, 1'b1);
    chk("R4 vec after reopen", irq_vec_o, 3'd1);

    // R5 disable keeps enable register
    gie_clr_i = 1; tick(); gie_clr_i = 0;
    chk("R5 disable masks", irq_req_o, 1'b0);
    gie_set_i = 1; tick(); gie_set_i = 0;
    chk("R5 enable reg kept", {irq_req_o, irq_vec_o}, {1'b1, 3'd1});
    gie_clr_i = 1; gie_set_i = 1; tick(); gie_clr_i = 0; gie_set_i = 0;
    chk("R5 disable beats enable", irq_req_o, 1'b0);
    // R4 write in same cycle as ack keeps mask open
    gie_set_i = 1; tick(); gie_set_i = 0;
    tmr1_unf_i = 1; tick(); tmr1_unf_i = 0;
    irq_ack_i = 1; ien_we_i = 1; ien_wdata_i = 8'h82; tick();
    irq_ack_i = 0; ien_we_i = 0;
    chk("R4 write wins over accept", {irq_req_o, irq_vec_o}, {1'b1, 3'd7});
    drain();

    // R6 port enable per pin
    pen_we_i = 1; pen_wdata_i = 4'b0010; tick(); pen_we_i = 0;
    port_i = 4'b0001; tick(3);
    chk("R6 disabled pin ignored", evt_o, 8'h00);
    port_i = 4'b0011; tick(3);
    chk("R6 enabled pin sets bit 2", evt_o, 8'h04);
    drain();

    // R7 external falling edge, R10 hold release
    hren_we_i = 1; hren_wdata_i = 8'h10; tick(); hren_we_i = 0;
    ext_n_i = 0; tick(2);
    chk("R7 not yet", evt_o, 8'h00);
    tick();
    chk("R7 falling edge sets bit 4", evt_o, 8'h10);
    chk("R10 hold pulse from edge", hold_release_o, 1'b1);
    tick();
    chk("R10 pulse one clock", hold_release_o, 1'b0);
    drain();
    tick(4);
    chk("R7 low level does not re-set", evt_o, 8'h00);
    ext_n_i = 1; tick(3);
    chk("R7 rising edge ignored", evt_o, 8'h00);

    hren_we_i = 1; hren_wdata_i = 8'h80; tick(); hren_we_i = 0;
    div_ovf_i = 1; tick(); div_ovf_i = 0;
    chk("R10 no pulse when hren bit 0", hold_release_o, 1'b0);
    tmr1_unf_i = 1; tick(); tmr1_unf_i = 0;
    chk("R10 pulse with mask closed", hold_release_o, 1'b1);
    chk("R10 no irq with mask closed", irq_req_o, 1'b0);
    drain();
    hren_we_i = 1; hren_wdata_i = 8'h68; tick(); hren_we_i = 0;
    tmr1_unf_i = 1; tick(); tmr1_unf_i = 0;
    chk("R1 reserved hren bits no effect", hold_release_o, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule